// File: doc/BRIEF.md
# Preamp Mode and Fault Controller

This block is the digital control core of a two-state (read/write) head preamplifier. From two configuration bits (an awake bit and an active bit), the read/write direction pin and a bank-write request, it selects one of five operating modes: sleep, idle, read, write and bank write. It reports the mode as a one-hot vector.

It also drives the shared fault output. The output has opposite active polarity in the two data modes:
- **Write mode:** the output rises on any write-side hazard. These are an open write head, a write head shorted to ground, write data that toggles too slowly, or a latched low-supply condition.
- **Read mode:** the output falls on an open or shorted read head. Each of these two detectors counts only when its own enable bit is set.
- **Bank write:** every fault source is masked and the low-supply detector is switched off.
- **Sleep and idle:** the output rests at the inactive level for the present direction pin.

Analog comparators are modelled as digital inputs. The write-data frequency supervisor is a saturating transition timer clocked by the system clock, with a programmable limit. Once it has flagged slow data, it needs two fresh transitions on the write-data line to clear.

Top module: `preamp_mode_ctl`

## Requirements
- R1: `mode_oh` is one-hot with bit 0 = sleep, bit 1 = idle, bit 2 = read, bit 3 = write and bit 4 = bank write. `mode_oh`, `fault_out` and `vlow_det_en` all take their new values at the first rising clock edge after the inputs change. During reset the outputs are: mode sleep, `fault_out` 0, `vlow_det_en` 1.
- R2: `cfg_awake` = 0 selects sleep, whatever the other inputs are.
- R3: `cfg_awake` = 1 with `cfg_active` = 0 selects idle, and `rd_nwr` has no effect on the mode.
- R4: With `cfg_awake` = `cfg_active` = 1, `rd_nwr` = 1 selects read. `rd_nwr` = 0 selects write, unless R5 applies.
- R5: Bank write is selected when `cfg_awake` = `cfg_active` = 1, `bank_req` = 1, `rd_nwr` = 0 and the present mode is read or bank write. Returning `rd_nwr` to 1 goes back to read. A `bank_req` raised while already in write leaves the mode at write.
- R6: In write mode `fault_out` is 1 when `wr_open_raw`, `wr_gnd_raw`, the slow-data flag or the low-supply flag is set. Otherwise it is 0.
- R7: In read mode `fault_out` is 0 when (`open_det_en` and `rd_open_raw`) or (`short_det_en` and `rd_short_raw`) holds. Otherwise it is 1.
- R8: In bank write, `fault_out` is 0 whatever the fault inputs are. `vlow_det_en` is 0, and the low-supply flag is cleared so it does not survive into a later write.
- R9: In sleep and idle, `fault_out` equals `rd_nwr`, which is the inactive level for the current direction.
- R10: In write mode the slow-data flag sets in the `slow_limit`-th consecutive write cycle with no transition on `wdata`, for `slow_limit` ≥ 1. The timer restarts at every transition and on every entry into write.
- R11: Once set, the slow-data flag clears at the second `wdata` transition that follows it. Leaving write mode also clears it.
- R12: `vlow_set` sets the low-supply flag and takes priority over `vlow_clr`, which clears it. Otherwise the flag holds its value. The flag affects `fault_out` only in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_awake | input | 1 | Configuration bit; 0 selects sleep |
| cfg_active | input | 1 | Configuration bit; 0 selects idle when awake |
| rd_nwr | input | 1 | Direction pin: 1 selects read, 0 selects write |
| bank_req | input | 1 | Bank-write request (servo enable) |
| open_det_en | input | 1 | Enables the read-head open detector |
| short_det_en | input | 1 | Enables the read-head short detector |
| wr_open_raw | input | 1 | Open write head comparator |
| wr_gnd_raw | input | 1 | Write head shorted to ground comparator |
| rd_open_raw | input | 1 | Open read head comparator |
| rd_short_raw | input | 1 | Shorted read head comparator |
| vlow_set | input | 1 | Low-supply assert threshold crossed |
| vlow_clr | input | 1 | Low-supply release threshold crossed |
| wdata | input | 1 | Write data level |
| slow_limit | input | CNT_W | Cycles without a transition before slow data is flagged |
| mode_oh | output | 5 | One-hot operating mode |
| fault_out | output | 1 | Fault level, polarity set by mode |
| vlow_det_en | output | 1 | Low-supply detector enable |

## Verification
Every output registers its result at the first rising edge after a stimulus. This includes the slow-data and low-supply contributions to `fault_out`, because they are formed from next-state values. The bench therefore applies inputs at a falling edge and compares at the following falling edge, one edge later.

The slow-data timer is the only delayed effect:
- A fault appears `slow_limit` edges after write entry or after the last transition.
- It clears on the edge that samples the second new transition.

The directed checks count those edges exactly, and the random phase compares every cycle against a bench model built from the requirements.

// File: rtl/preamp_mode_pkg.sv
package preamp_mode_pkg;

   typedef enum logic [4:0] {
      PM_SLEEP = 5'b00001,
      PM_IDLE  = 5'b00010,
      PM_READ  = 5'b00100,
      PM_WRITE = 5'b01000,
      PM_BANK  = 5'b10000
   } pm_mode_e;

   localparam int PM_NUM_MODES = 5;

endpackage

// File: rtl/preamp_mode_dec.sv
module preamp_mode_dec
   import preamp_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_awake,
   input  logic     cfg_active,
   input  logic     rd_nwr,
   input  logic     bank_req,
   output pm_mode_e mode_nxt,
   output pm_mode_e mode_q
);

   logic from_read_side;

   assign from_read_side = (mode_q == PM_READ) || (mode_q == PM_BANK);

   always_comb begin
      if (!cfg_awake)
         mode_nxt = PM_SLEEP;
      else if (!cfg_active)
         mode_nxt = PM_IDLE;
      else if (rd_nwr)
         mode_nxt = PM_READ;
      else if (bank_req && from_read_side)
         mode_nxt = PM_BANK;
      else
         mode_nxt = PM_WRITE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= PM_SLEEP;
      else
         mode_q <= mode_nxt;
   end

   // R1: exactly one mode bit is set at all times
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_q) == 1);

   // R2: sleep request wins over everything
   p_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_awake |=> mode_q == PM_SLEEP);

   // R3: idle independent of direction pin
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_awake && !cfg_active) |=> mode_q == PM_IDLE);

   // R5: a request raised during plain write does not switch to bank write
   p_no_bank_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_WRITE && cfg_awake && cfg_active && !rd_nwr) |=> mode_q == PM_WRITE);

endmodule

// File: rtl/preamp_wd_monitor.sv
module preamp_wd_monitor #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             wdata,
   input  logic [CNT_W-1:0] limit,
   output logic             slow_nxt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             wd_q;
   logic             toggle;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             slow_q;
   logic             seen_q, seen_nxt;

   assign toggle = wdata ^ wd_q;

   always_comb begin
      cnt_nxt  = cnt_q;
      slow_nxt = slow_q;
      seen_nxt = seen_q;
      if (!enable) begin
         cnt_nxt  = '0;
         slow_nxt = 1'b0;
         seen_nxt = 1'b0;
      end else begin
         if (toggle)
            cnt_nxt = '0;
         else if (cnt_q != CNT_MAX)
            cnt_nxt = cnt_q + CNT_ONE;
         if (slow_q) begin
            if (toggle) begin
               if (seen_q) begin
                  slow_nxt = 1'b0;
                  seen_nxt = 1'b0;
               end else begin
                  seen_nxt = 1'b1;
               end
            end
         end else begin
            slow_nxt = (cnt_nxt >= limit);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q   <= 1'b0;
         cnt_q  <= '0;
         slow_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         wd_q   <= wdata;
         cnt_q  <= cnt_nxt;
         slow_q <= slow_nxt;
         seen_q <= seen_nxt;
      end
   end

   // R10: flag never survives outside write mode
   p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !slow_q);

   // R11: a set flag holds while no transition arrives
   p_slow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_q && enable && !toggle) |=> slow_q);

endmodule

// File: rtl/preamp_vlow_hyst.sv
module preamp_vlow_hyst (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_off,
   input  logic set_in,
   input  logic clr_in,
   output logic flag_nxt
);

   logic flag_q;

   always_comb begin
      if (hold_off)
         flag_nxt = 1'b0;
      else if (set_in)
         flag_nxt = 1'b1;
      else if (clr_in)
         flag_nxt = 1'b0;
      else
         flag_nxt = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else
         flag_q <= flag_nxt;
   end

   // R8: detector held off clears the flag
   p_vlow_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_off |=> !flag_q);

   // R12: set has priority when the detector runs
   p_vlow_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (set_in && !hold_off) |=> flag_q);

endmodule

// File: rtl/preamp_fault_mux.sv
module preamp_fault_mux
   import preamp_mode_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pm_mode_e mode_nxt,
   input  logic     rd_nwr,
   input  logic     wr_open_raw,
   input  logic     wr_gnd_raw,
   input  logic     slow_flag,
   input  logic     vlow_flag,
   input  logic     open_det_en,
   input  logic     short_det_en,
   input  logic     rd_open_raw,
   input  logic     rd_short_raw,
   output logic     fault_out
);

   logic wr_hazard, rd_hazard, fault_d;

   assign wr_hazard = wr_open_raw | wr_gnd_raw | slow_flag | vlow_flag;
   assign rd_hazard = (open_det_en & rd_open_raw) | (short_det_en & rd_short_raw);

   always_comb begin
      case (mode_nxt)
         PM_WRITE: fault_d = wr_hazard;
         PM_READ:  fault_d = ~rd_hazard;
         PM_BANK:  fault_d = 1'b0;
         default:  fault_d = rd_nwr;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic fault_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fault_q <= 1'b0;
            else
               fault_q <= fault_d;
         end
         assign fault_out = fault_q;

         // R8: bank write keeps the output quiet
         p_bank_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_nxt == PM_BANK) |=> !fault_out);

         // R7: with both read detectors off the read output stays high
         p_read_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_nxt == PM_READ && !open_det_en && !short_det_en) |=> fault_out);

         // R6: an open write head raises the output in write
         p_wr_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_nxt == PM_WRITE && wr_open_raw) |=> fault_out);
      end else begin : g_comb
         assign fault_out = fault_d;
      end
   endgenerate

endmodule

// File: rtl/preamp_mode_ctl.sv
module preamp_mode_ctl
   import preamp_mode_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit FAULT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_awake,
   input  logic             cfg_active,
   input  logic             rd_nwr,
   input  logic             bank_req,
   input  logic             open_det_en,
   input  logic             short_det_en,
   input  logic             wr_open_raw,
   input  logic             wr_gnd_raw,
   input  logic             rd_open_raw,
   input  logic             rd_short_raw,
   input  logic             vlow_set,
   input  logic             vlow_clr,
   input  logic             wdata,
   input  logic [CNT_W-1:0] slow_limit,
   output logic [4:0]       mode_oh,
   output logic             fault_out,
   output logic             vlow_det_en
);

   initial begin
      a_cnt_w_range: assert (CNT_W >= 2 && CNT_W <= 32)
         else $error("CNT_W must be between 2 and 32");
      a_mode_width: assert (PM_NUM_MODES == 5)
         else $error("mode encoding must have five states");
   end

   pm_mode_e mode_nxt, mode_q;
   logic     slow_nxt, vlow_nxt;

   preamp_mode_dec u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_awake  (cfg_awake),
      .cfg_active (cfg_active),
      .rd_nwr     (rd_nwr),
      .bank_req   (bank_req),
      .mode_nxt   (mode_nxt),
      .mode_q     (mode_q)
   );

   preamp_wd_monitor #(.CNT_W(CNT_W)) u_wdmon (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (mode_nxt == PM_WRITE),
      .wdata    (wdata),
      .limit    (slow_limit),
      .slow_nxt (slow_nxt)
   );

   preamp_vlow_hyst u_vlow (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_off (mode_nxt == PM_BANK),
      .set_in   (vlow_set),
      .clr_in   (vlow_clr),
      .flag_nxt (vlow_nxt)
   );

   preamp_fault_mux #(.REG_OUT(FAULT_REG)) u_fault (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_nxt     (mode_nxt),
      .rd_nwr       (rd_nwr),
      .wr_open_raw  (wr_open_raw),
      .wr_gnd_raw   (wr_gnd_raw),
      .slow_flag    (slow_nxt),
      .vlow_flag    (vlow_nxt),
      .open_det_en  (open_det_en),
      .short_det_en (short_det_en),
      .rd_open_raw  (rd_open_raw),
      .rd_short_raw (rd_short_raw),
      .fault_out    (fault_out)
   );

   assign mode_oh     = mode_q;
   assign vlow_det_en = (mode_q != PM_BANK);

   // R8: detector enable drops for exactly the bank-write mode
   p_det_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_nxt == PM_BANK) |=> !vlow_det_en);

   // R9: sleep and idle rest at the direction-pin level
   p_rest_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_nxt == PM_SLEEP || mode_nxt == PM_IDLE) |=> fault_out == $past(rd_nwr));

endmodule

// File: tb/preamp_mode_ctl_tb_top.sv
module preamp_mode_ctl_tb_top;

   localparam int CW = 8;
   localparam logic [4:0] M_SLEEP = 5'b00001, M_IDLE = 5'b00010, M_READ = 5'b00100,
                          M_WRITE = 5'b01000, M_BANK = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic awake = 0, active = 0, rd_nwr = 0, bank = 0, oen = 0, sen = 0;
   logic wopen = 0, wgnd = 0, ropen = 0, rshort = 0, vset = 0, vclr = 0, wd = 0;
   logic [CW-1:0] limit = 8'd4;
   logic [4:0] mode_oh;
   logic fault_out, vlow_det_en;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;

   // bench model state
   logic [4:0] m_mode = M_SLEEP;
   logic m_fault = 0, m_wdq = 0, m_slow = 0, m_seen = 0, m_vlow = 0;
   logic [CW-1:0] m_cnt = '0;

   always #4 clk = ~clk;

   preamp_mode_ctl #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_awake(awake), .cfg_active(active),
      .rd_nwr(rd_nwr), .bank_req(bank), .open_det_en(oen), .short_det_en(sen),
      .wr_open_raw(wopen), .wr_gnd_raw(wgnd), .rd_open_raw(ropen),
      .rd_short_raw(rshort), .vlow_set(vset), .vlow_clr(vclr), .wdata(wd),
      .slow_limit(limit), .mode_oh(mode_oh), .fault_out(fault_out),
      .vlow_det_en(vlow_det_en)
   );

   function automatic logic [4:0] exp_mode(logic [4:0] cur);
      if (!awake) return M_SLEEP;
      if (!active) return M_IDLE;
      if (rd_nwr) return M_READ;
      if (bank && (cur == M_READ || cur == M_BANK)) return M_BANK;
      return M_WRITE;
   endfunction

   function automatic logic exp_fault(logic [4:0] md, logic slow, logic vlow);
      case (md)
         M_WRITE: return wopen | wgnd | slow | vlow;
         M_READ:  return ~((oen & ropen) | (sen & rshort));
         M_BANK:  return 1'b0;
         default: return rd_nwr;
      endcase
   endfunction

   task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   function automatic string mode_tag(logic [4:0] md);
      case (md)
         M_SLEEP: return "R2";
         M_IDLE:  return "R3";
         M_BANK:  return "R5";
         default: return "R4";
      endcase
   endfunction

   function automatic string fault_tag(logic [4:0] md);
      case (md)
         M_WRITE: return "R6";
         M_READ:  return "R7";
         M_BANK:  return "R8";
         default: return "R9";
      endcase
   endfunction

   // one clock: model follows the edge, outputs compared at the next falling edge
   task automatic step();
      logic tg;
      @(posedge clk);
      m_mode = exp_mode(m_mode);
      tg = wd ^ m_wdq;
      m_wdq = wd;
      if (m_mode == M_BANK) m_vlow = 0;
      else if (vset) m_vlow = 1;
      else if (vclr) m_vlow = 0;
      if (m_mode != M_WRITE) begin
         m_cnt = '0; m_slow = 0; m_seen = 0;
      end else begin
         if (tg) m_cnt = '0;
         else if (m_cnt != {CW{1'b1}}) m_cnt = m_cnt + 1'b1;
         if (m_slow) begin
            if (tg) begin
               if (m_seen) begin m_slow = 0; m_seen = 0; end
               else m_seen = 1;
            end
         end else m_slow = (m_cnt >= limit);
      end
      m_fault = exp_fault(m_mode, m_slow, m_vlow);
      @(negedge clk);
      chk(mode_tag(m_mode), mode_oh, m_mode);
      chk(fault_tag(m_mode), {4'b0, fault_out}, {4'b0, m_fault});
      chk("R8", {4'b0, vlow_det_en}, {4'b0, m_mode != M_BANK});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000 && !done) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected<=200000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", mode_oh, M_SLEEP);
      chk("R1", {4'b0, fault_out}, 5'b0);
      chk("R1", {4'b0, vlow_det_en}, 5'b1);
      rst_n = 1;

      // R2: sleep wins even with active and read requested
      awake = 0; active = 1; rd_nwr = 1; step();
      chk("R2", mode_oh, M_SLEEP);
      chk("R9", {4'b0, fault_out}, 5'b1);

      // R3: idle ignores direction pin; R9 rest level follows it
      awake = 1; active = 0; rd_nwr = 0; step();
      chk("R3", mode_oh, M_IDLE);
      chk("R9", {4'b0, fault_out}, 5'b0);
      rd_nwr = 1; step();
      chk("R3", mode_oh, M_IDLE);
      chk("R9", {4'b0, fault_out}, 5'b1);

      // R4 / R7: read with detector enables
      active = 1; ropen = 1; oen = 0; step();
      chk("R4", mode_oh, M_READ);
      chk("R7", {4'b0, fault_out}, 5'b1);
      oen = 1; step();
      chk("R7", {4'b0, fault_out}, 5'b0);
      oen = 0; ropen = 0; rshort = 1; sen = 1; step();
      chk("R7", {4'b0, fault_out}, 5'b0);
      rshort = 0; sen = 0;

      // R5 / R8: bank write from read masks faults and detector
      bank = 1; rd_nwr = 0; wopen = 1; vset = 1; step();
      chk("R5", mode_oh, M_BANK);
      chk("R8", {4'b0, fault_out}, 5'b0);
      chk("R8", {4'b0, vlow_det_en}, 5'b0);
      vset = 0; wopen = 0; rd_nwr = 1; step();
      chk("R5", mode_oh, M_READ);
      // R8: flag did not survive into write
      bank = 0; rd_nwr = 0; limit = 8'd50; step();
      chk("R4", mode_oh, M_WRITE);
      chk("R8", {4'b0, fault_out}, 5'b0);
      // R5: request raised in write stays write
      bank = 1; step();
      chk("R5", mode_oh, M_WRITE);
      bank = 0;

      // R6 / R12: write hazards and low-supply hysteresis
      wgnd = 1; step();
      chk("R6", {4'b0, fault_out}, 5'b1);
      wgnd = 0; vset = 1; vclr = 1; step();
      chk("R12", {4'b0, fault_out}, 5'b1);
      vset = 0; vclr = 0; step();
      chk("R12", {4'b0, fault_out}, 5'b1);
      vclr = 1; step();
      chk("R12", {4'b0, fault_out}, 5'b0);
      vclr = 0; vset = 1; rd_nwr = 1; step();
      chk("R12", {4'b0, fault_out}, 5'b1);
      vset = 0; rd_nwr = 0; step();
      chk("R12", {4'b0, fault_out}, 5'b1);
      vclr = 1; step(); vclr = 0;

      // R10: slow-data timer from write entry
      awake = 0; step();
      awake = 1; limit = 8'd4; step(); step(); step();
      chk("R10", {4'b0, fault_out}, 5'b0);
      step();
      chk("R10", {4'b0, fault_out}, 5'b1);
      // R11: clears on second transition
      wd = ~wd; step();
      chk("R11", {4'b0, fault_out}, 5'b1);
      wd = ~wd; step();
      chk("R11", {4'b0, fault_out}, 5'b0);
      // R10: transition restarts timer
      step(); step(); wd = ~wd; step(); step(); step();
      chk("R10", {4'b0, fault_out}, 5'b0);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         awake  = ($urandom_range(0, 19) != 0);
         active = ($urandom_range(0, 14) != 0);
         if ($urandom_range(0, 5) == 0) rd_nwr = ~rd_nwr;
         if ($urandom_range(0, 7) == 0) bank = ~bank;
         oen    = $urandom_range(0, 1);
         sen    = $urandom_range(0, 1);
         wopen  = ($urandom_range(0, 15) == 0);
         wgnd   = ($urandom_range(0, 15) == 0);
         ropen  = ($urandom_range(0, 3) == 0);
         rshort = ($urandom_range(0, 3) == 0);
         vset   = ($urandom_range(0, 30) == 0);
         vclr   = ($urandom_range(0, 10) == 0);
         if ($urandom_range(0, 3) == 0) wd = ~wd;
         if ($urandom_range(0, 99) == 0) limit = CW'($urandom_range(1, 8));
         step();
      end
      finish_run();
   end

endmodule